// File: doc/BRIEF.md
# Multi-Pulse Serializer Pattern Generator

This block produces a repeating pulse train for one output channel. Each clock cycle it hands a parallel word to a high-speed serializer, and each bit of that word stands for one serial unit interval. Bit 0 is sent first. Software describes the train with a period, a global delay, an enable, and a small table of pulses. Each pulse is a start position and a width, both counted in unit intervals. For every bit of the word, the block works out that bit's position inside the period, shifts it back by the delay, and tests it against every table entry.

All settings are written into a shadow copy and then committed with a strobe. The committed copy becomes active only after a period boundary, so the stream never pauses and a downstream receiver stays phase locked while the pattern changes. The position counter steps in whole words and keeps the sub-word remainder, so a period that is not a multiple of the word width repeats exactly.

Top module: `pulse_pattern_gen`

## Requirements
- R1: Each cycle, `tx_word` bit b (bit 0 first in time) is 1 when the channel is enabled and the bit's pattern position lies in `[start, start+width)` of some table entry. The output register adds one cycle of latency after the position counter.
- R2: The position of bit b is `(base + b) mod period`. `base` advances by the word width every cycle, modulo the period, so periods that are not multiples of the word width repeat exactly.
- R3: The pattern position is `(position - delay) mod period`. A delay of d moves the whole pattern d unit intervals later. Delay must be less than the period.
- R4: A pulse that crosses a word boundary continues without a gap into the next word.
- R5: A table entry with width 0 produces no output bits.
- R6: A pulse whose end lies beyond the period is cut off at the period end and does not spill into the next repetition.
- R7: Overlapping pulses combine as a logical OR.
- R8: While the active enable is 0, `tx_word` is all zeros and the position counter keeps running. On re-enable, the pattern resumes in the phase of the uninterrupted count.
- R9: Shadow writes have no effect until `cfg_commit`. A commit takes effect from the first word after a word in which the period wraps. The counter carries its sub-word remainder across the swap.
- R10: A period written below the word width is stored as the word width.
- R11: After reset, `tx_word` is zero, the active set is disabled with period equal to the word width, and the position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pulse_we | input | 1 | Write one shadow pulse entry |
| cfg_pulse_idx | input | IDX_W | Entry index for the pulse write |
| cfg_pulse_start | input | 16 | Pulse start in unit intervals |
| cfg_pulse_width | input | 16 | Pulse width in unit intervals |
| cfg_ctrl_we | input | 1 | Write shadow period, delay and enable |
| cfg_period | input | 16 | Period in unit intervals |
| cfg_delay | input | 16 | Global delay in unit intervals |
| cfg_enable | input | 1 | Channel output enable |
| cfg_commit | input | 1 | Request a swap of shadow into active at the next wrap |
| tx_word | output | WORD_W | Parallel word for the serializer, bit 0 first |

## Verification
The bench sweeps several periods, some word-aligned and some not, against three delays and two pulse tables. Every output word is compared with a model that works in plain modulo arithmetic. The tables include a pulse that crosses a word boundary, a zero-width entry, overlapping entries and entries that run past the period end. A design that dropped the sub-word remainder would drift its phase, one that mishandled truncation would put stray bits at the start of the next period, and a boundary-crossing bug would leave a gap between words. Separate phases check that uncommitted writes change nothing, that a commit during a long period waits for the wrap, that disabling gives zeros without losing phase, and that a short period is raised to the word width.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  localparam int unsigned POS_W = 16;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [POS_W:0]   posx_t;

  typedef struct packed {
    pos_t start;
    pos_t width;
  } pulse_t;

  // position of a bit at offset 'off' from the word base, folded into the period
  function automatic pos_t fold_pos(pos_t base, pos_t off, pos_t period);
    posx_t s;
    s = {1'b0, base} + {1'b0, off};
    if (s >= {1'b0, period}) s = s - {1'b0, period};
    return s[POS_W-1:0];
  endfunction

  // undo the channel delay, modulo the period
  function automatic pos_t pattern_pos(pos_t p, pos_t delay, pos_t period);
    if (p >= delay) return p - delay;
    return p + (period - delay);
  endfunction

  // overflow-free interval test: q in [start, start+width)
  function automatic logic pulse_covers(pos_t q, pulse_t pl);
    return (q >= pl.start) && ((q - pl.start) < pl.width);
  endfunction

  function automatic pos_t floor_period(pos_t req, pos_t min_v);
    return (req < min_v) ? min_v : req;
  endfunction

endpackage

// File: rtl/pgen_phase.sv
module pgen_phase
  import pgen_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  pos_t period,
  output pos_t base_pos,
  output logic wrap_evt
);

  localparam posx_t STEP = posx_t'(WORD_W);

  posx_t ahead;

  assign ahead    = {1'b0, base_pos} + STEP;
  assign wrap_evt = (ahead >= {1'b0, period});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_pos <= '0;
    end else if (wrap_evt) begin
      base_pos <= pos_t'(ahead - {1'b0, period});
    end else begin
      base_pos <= ahead[POS_W-1:0];
    end
  end

endmodule

// File: rtl/pgen_cfg_bank.sv
module pgen_cfg_bank
  import pgen_pkg::*;
#(
  parameter int unsigned WORD_W   = 64,
  parameter int unsigned N_PULSES = 4,
  localparam int unsigned IDX_W   = (N_PULSES > 1) ? $clog2(N_PULSES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pulse_we,
  input  logic [IDX_W-1:0]           pulse_idx,
  input  pos_t                       pulse_start,
  input  pos_t                       pulse_width,
  input  logic                       ctrl_we,
  input  pos_t                       ctrl_period,
  input  pos_t                       ctrl_delay,
  input  logic                       ctrl_enable,
  input  logic                       commit,
  input  logic                       wrap_evt,
  output pulse_t [N_PULSES-1:0]      act_pulses,
  output pos_t                       act_period,
  output pos_t                       act_delay,
  output logic                       act_enable,
  output logic                       swap_evt
);

  localparam pos_t MIN_PER = pos_t'(WORD_W);

  pulse_t [N_PULSES-1:0] sh_pulses;
  pos_t                  sh_period;
  pos_t                  sh_delay;
  logic                  sh_enable;
  logic                  pending;

  assign swap_evt = wrap_evt && (pending || commit);

  for (genvar i = 0; i < N_PULSES; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_pulses[i] <= '0;
      end else if (pulse_we && (pulse_idx == IDX_W'(i))) begin
        sh_pulses[i] <= '{start: pulse_start, width: pulse_width};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_pulses[i] <= '0;
      end else if (swap_evt) begin
        act_pulses[i] <= sh_pulses[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_period <= MIN_PER;
      sh_delay  <= '0;
      sh_enable <= 1'b0;
    end else if (ctrl_we) begin
      sh_period <= floor_period(ctrl_period, MIN_PER);
      sh_delay  <= ctrl_delay;
      sh_enable <= ctrl_enable;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_period <= MIN_PER;
      act_delay  <= '0;
      act_enable <= 1'b0;
    end else if (swap_evt) begin
      act_period <= sh_period;
      act_delay  <= sh_delay;
      act_enable <= sh_enable;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (swap_evt) begin
      pending <= 1'b0;
    end else if (commit) begin
      pending <= 1'b1;
    end
  end

endmodule

// File: rtl/pgen_word_build.sv
module pgen_word_build
  import pgen_pkg::*;
#(
  parameter int unsigned WORD_W   = 64,
  parameter int unsigned N_PULSES = 4
) (
  input  pos_t                  base_pos,
  input  pos_t                  period,
  input  pos_t                  delay,
  input  logic                  enable,
  input  pulse_t [N_PULSES-1:0] pulses,
  output logic [WORD_W-1:0]     word
);

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    pos_t p_abs;
    pos_t p_pat;
    logic hit;

    assign p_abs = fold_pos(base_pos, pos_t'(b), period);
    assign p_pat = pattern_pos(p_abs, delay, period);

    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < N_PULSES; i++) begin
        hit = hit | pulse_covers(p_pat, pulses[i]);
      end
    end

    assign word[b] = enable & hit;
  end

endmodule

// File: rtl/pulse_pattern_gen.sv
module pulse_pattern_gen
  import pgen_pkg::*;
#(
  parameter int unsigned WORD_W   = 64,
  parameter int unsigned N_PULSES = 4,
  localparam int unsigned IDX_W   = (N_PULSES > 1) ? $clog2(N_PULSES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pulse_we,
  input  logic [IDX_W-1:0]  cfg_pulse_idx,
  input  logic [15:0]       cfg_pulse_start,
  input  logic [15:0]       cfg_pulse_width,
  input  logic              cfg_ctrl_we,
  input  logic [15:0]       cfg_period,
  input  logic [15:0]       cfg_delay,
  input  logic              cfg_enable,
  input  logic              cfg_commit,
  output logic [WORD_W-1:0] tx_word
);

  // named internal events, observed by the bound checker
  pos_t                  base_pos;
  logic                  wrap_evt;
  logic                  swap_evt;
  pulse_t [N_PULSES-1:0] act_pulses;
  pos_t                  act_period;
  pos_t                  act_delay;
  logic                  act_enable;
  logic [WORD_W-1:0]     next_word;

  pgen_phase #(.WORD_W(WORD_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .period   (act_period),
    .base_pos (base_pos),
    .wrap_evt (wrap_evt)
  );

  pgen_cfg_bank #(.WORD_W(WORD_W), .N_PULSES(N_PULSES)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_we    (cfg_pulse_we),
    .pulse_idx   (cfg_pulse_idx),
    .pulse_start (cfg_pulse_start),
    .pulse_width (cfg_pulse_width),
    .ctrl_we     (cfg_ctrl_we),
    .ctrl_period (cfg_period),
    .ctrl_delay  (cfg_delay),
    .ctrl_enable (cfg_enable),
    .commit      (cfg_commit),
    .wrap_evt    (wrap_evt),
    .act_pulses  (act_pulses),
    .act_period  (act_period),
    .act_delay   (act_delay),
    .act_enable  (act_enable),
    .swap_evt    (swap_evt)
  );

  pgen_word_build #(.WORD_W(WORD_W), .N_PULSES(N_PULSES)) u_build (
    .base_pos (base_pos),
    .period   (act_period),
    .delay    (act_delay),
    .enable   (act_enable),
    .pulses   (act_pulses),
    .word     (next_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_word <= '0;
    else        tx_word <= next_word;
  end

endmodule

// File: rtl/pgen_checker.sv
module pgen_checker
  import pgen_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input pos_t              base_pos,
  input logic              wrap_evt,
  input logic              swap_evt,
  input pos_t              act_period,
  input pos_t              act_delay,
  input logic              act_enable,
  input logic [WORD_W-1:0] tx_word
);

  a_r9_swap_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |-> wrap_evt);

  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_evt |=> ($stable(act_period) && $stable(act_delay) && $stable(act_enable)));

  a_r2_base_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    base_pos < act_period);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> (32'(base_pos) == 32'($past(base_pos)) + WORD_W));

  a_r10_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
    32'(act_period) >= WORD_W);

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !act_enable |=> (tx_word == '0));

endmodule

bind pulse_pattern_gen pgen_checker #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .base_pos   (base_pos),
  .wrap_evt   (wrap_evt),
  .swap_evt   (swap_evt),
  .act_period (act_period),
  .act_delay  (act_delay),
  .act_enable (act_enable),
  .tx_word    (tx_word)
);

// File: tb/pulse_pattern_gen_bench.sv
module pulse_pattern_gen_bench;

  localparam int W = 64;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_pulse_we = 1'b0;
  logic [1:0]    cfg_pulse_idx = '0;
  logic [15:0]   cfg_pulse_start = '0;
  logic [15:0]   cfg_pulse_width = '0;
  logic          cfg_ctrl_we = 1'b0;
  logic [15:0]   cfg_period = '0;
  logic [15:0]   cfg_delay = '0;
  logic          cfg_enable = 1'b0;
  logic          cfg_commit = 1'b0;
  logic [W-1:0]  tx_word;

  always #2.5 clk = ~clk;

  pulse_pattern_gen #(.WORD_W(W), .N_PULSES(N)) u_pulse_pattern_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_pulse_we(cfg_pulse_we), .cfg_pulse_idx(cfg_pulse_idx),
    .cfg_pulse_start(cfg_pulse_start), .cfg_pulse_width(cfg_pulse_width),
    .cfg_ctrl_we(cfg_ctrl_we), .cfg_period(cfg_period), .cfg_delay(cfg_delay),
    .cfg_enable(cfg_enable), .cfg_commit(cfg_commit), .tx_word(tx_word)
  );

  // ---------------- reference model (plain modulo arithmetic) -------------
  int m_base, m_per, m_del, m_sh_per, m_sh_del;
  bit m_en, m_sh_en, m_pend;
  int m_s [N];
  int m_w [N];
  int m_sh_s [N];
  int m_sh_w [N];
  logic [W-1:0] exp_word;

  function automatic logic [W-1:0] model_word();
    logic [W-1:0] r;
    r = '0;
    for (int b = 0; b < W; b++) begin
      int p;
      int q;
      p = (m_base + b) % m_per;
      q = (p + m_per - m_del) % m_per;
      for (int i = 0; i < N; i++)
        if (m_en && q >= m_s[i] && q < m_s[i] + m_w[i]) r[b] = 1'b1;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_per = W; m_del = 0; m_en = 0; m_pend = 0;
      m_sh_per = W; m_sh_del = 0; m_sh_en = 0;
      for (int i = 0; i < N; i++) begin
        m_s[i] = 0; m_w[i] = 0; m_sh_s[i] = 0; m_sh_w[i] = 0;
      end
      exp_word = '0;
    end else begin
      bit wr;
      bit sw;
      int nb;
      exp_word = model_word();
      wr = (m_base + W >= m_per);
      sw = wr && (m_pend || cfg_commit);
      nb = (m_base + W) % m_per;
      if (sw) begin
        m_per = m_sh_per; m_del = m_sh_del; m_en = m_sh_en;
        for (int i = 0; i < N; i++) begin m_s[i] = m_sh_s[i]; m_w[i] = m_sh_w[i]; end
        m_pend = 0;
      end else if (cfg_commit) begin
        m_pend = 1;
      end
      if (cfg_pulse_we) begin
        m_sh_s[cfg_pulse_idx] = int'(cfg_pulse_start);
        m_sh_w[cfg_pulse_idx] = int'(cfg_pulse_width);
      end
      if (cfg_ctrl_we) begin
        m_sh_per = (int'(cfg_period) < W) ? W : int'(cfg_period);
        m_sh_del = int'(cfg_delay);
        m_sh_en  = cfg_enable;
      end
      m_base = nb;
    end
  end

  // ---------------- checking ----------------
  int    n_chk = 0;
  int    n_fail = 0;
  bit    chk_on = 0;
  bit    done = 0;
  string cur_req = "R11";

  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_chk++;
      if (tx_word !== exp_word) begin
        n_fail++;
        $display("FAIL %s: tx_word=%h expected %h", cur_req, tx_word, exp_word);
      end
    end
  end

  task automatic wr_pulse(input int i, input int s, input int w);
    cfg_pulse_we = 1; cfg_pulse_idx = 2'(i);
    cfg_pulse_start = 16'(s); cfg_pulse_width = 16'(w);
    @(negedge clk);
    cfg_pulse_we = 0;
  endtask

  task automatic wr_ctrl(input int per, input int del, input bit en);
    cfg_ctrl_we = 1; cfg_period = 16'(per); cfg_delay = 16'(del); cfg_enable = en;
    @(negedge clk);
    cfg_ctrl_we = 0;
  endtask

  task automatic do_commit();
    cfg_commit = 1;
    @(negedge clk);
    cfg_commit = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  int pers [5] = '{64, 100, 128, 191, 250};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_on = 1;
    cur_req = "R11 reset state";
    run(4);

    // R8: disabled channel stays quiet, counter keeps running
    cur_req = "R8 disabled";
    wr_pulse(0, 3, 5); wr_pulse(1, 70, 20);
    wr_ctrl(150, 0, 0);
    do_commit();
    run(20);
    // R9: shadow enable without commit has no effect
    cur_req = "R9 uncommitted write";
    wr_ctrl(150, 0, 1);
    run(12);
    cur_req = "R8 re-enable phase";
    do_commit();
    run(20);

    // sweep: periods x delays x tables
    for (int pi = 0; pi < 5; pi++) begin
      for (int di = 0; di < 3; di++) begin
        for (int set = 0; set < 2; set++) begin
          int per;
          int del;
          per = pers[pi];
          del = (di == 0) ? 0 : ((di == 1) ? 7 : per - 1);
          if (set == 0) begin
            cur_req = (di == 0) ? "R1/R4/R5/R6 table A" : "R3 delay table A";
            wr_pulse(0, 0, 1);
            wr_pulse(1, 60, 10);
            wr_pulse(2, per - 3, 10);
            wr_pulse(3, 20, 0);
          end else begin
            cur_req = (di == 0) ? "R2/R7 table B" : "R3 delay table B";
            wr_pulse(0, 5, 30);
            wr_pulse(1, 15, 30);
            wr_pulse(2, per - 1, 1);
            wr_pulse(3, 40, per);
          end
          wr_ctrl(per, del, 1);
          do_commit();
          run((3 * per) / W + 6);
        end
      end
    end

    // R9: commit during a long period waits for the wrap
    cur_req = "R9 long period";
    wr_pulse(0, 10, 100); wr_pulse(1, 500, 3); wr_pulse(2, 990, 20); wr_pulse(3, 0, 0);
    wr_ctrl(1000, 0, 1);
    do_commit();
    run(40);
    cur_req = "R9 shadow only";
    wr_ctrl(64, 0, 1);
    run(8);
    cur_req = "R9 deferred swap";
    do_commit();
    run(24);

    // R10: short period raised to the word width
    cur_req = "R10 period floor";
    wr_pulse(0, 50, 20);
    wr_ctrl(10, 0, 1);
    do_commit();
    run(30);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run not complete, actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule